// File: doc/BRIEF.md
# Transfer Descriptor Command/Status Register Bank

This block holds the descriptor for one outbound transfer and sits on a simple configuration bus. Writes take one cycle and reads are combinational. Software first fills in the extended address, the remote address, the local address and the length. It then writes a control word that gives the output port and interrupt enable. Finally it writes the command word, which carries the packet format, the transaction code, the hop count and the doorbell information. The command write launches the transfer.

On a launch the bank raises a busy flag and gives a one-cycle strobe to the transmit engine. It also presents every descriptor field in packed form, including the packet-type byte. Busy stays up until the engine reports completion with a 3-bit result code. If the interrupt enable was set, busy also stays up until software acknowledges the interrupt.

While busy, descriptor accesses are refused and the result code reads as zero. A command with a format the bank does not support is never launched. It completes on its own with the unsupported-type code.

Top module: `xdb_bank`

Register map (word address on `cfg_addr`):

| Address | Contents |
|---|---|
| 0 | Extended address. |
| 1 | Remote address. |
| 2 | Local address. |
| 3 | Length, in the low `LEN_W` bits. |
| 4 | Control word: bits [PORT_W-1:0] give the output port, bit 8 is the interrupt enable. |
| 5 | Command word: bits [7:0] give the hop count, bits [11:8] the transaction code, bits [15:12] the format, bits [31:16] the doorbell information. |
| 6 | Status, read only: bit 0 busy, bits [3:1] result, bit 4 sticky violation, bit 5 interrupt. |
| 7 | Write-one-to-clear: bit 0 acknowledges the interrupt, bit 1 clears the violation. Reads return 0. |

Result codes:

| Code | Meaning |
|---|---|
| 000 | Success. |
| 001 | Response timeout. |
| 010 | Blocked by Xoff flow control. |
| 011 | Error response or bad response length. |
| 100 | Unsupported type or invalid field encoding. |
| 101 | DMA data error. |
| 110 | Doorbell retry, or test-and-swap refused. |
| 111 | No outbound credit at the requested priority. |

## Requirements
- R1: After reset, busy, irq and tx_launch are 0, and the status word at address 6 reads 0. A result of 000 means success.
- R2: While idle, a write to address 0 to 4 is stored, reads back at the same address and appears on the matching tx_ field. Length reads back truncated to LEN_W bits.
- R3: A command write (address 5) while idle with a supported format raises busy and tx_launch in the cycle after the write. tx_launch lasts exactly one cycle.
- R4: tx_ptype carries the format in bits [7:4]. For formats 2, 5 and 8, bits [3:0] carry the transaction code. For all other formats bits [3:0] are 0.
- R5: tx_hop, tx_dbell and tx_port present the hop count, doorbell information and output port as written.
- R6: While busy, writes to addresses 0 to 5 are dropped and set the sticky violation bit (status bit 4). Reads of addresses 0 to 5 return 0. Writing 1 to bit 1 of address 7 clears the violation bit.
- R7: While busy, the result field (status bits [3:1]) reads 000. After completion it holds the tx_code that came with tx_done.
- R8: With the interrupt enable clear, busy falls in the cycle after tx_done and irq stays 0.
- R9: With the interrupt enable set (address 4, bit 8), irq and busy are 1 from the cycle after tx_done. Both stay 1 until a write of 1 to bit 0 of address 7, and both are 0 in the cycle after that write.
- R10: A command whose format is not in FMT_SUPPORT raises no tx_launch. Busy is 1 for one cycle, then the result is 100 (unsupported type). With the interrupt enable set, completion waits for the acknowledge as in R9.
- R11: tx_done while idle is ignored, and the stored result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read enable |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, 0 when cfg_rd is low |
| busy | output | 1 | Transfer pending; register access blocked |
| irq | output | 1 | Completion interrupt request |
| tx_launch | output | 1 | One-cycle start strobe to the transmit engine |
| tx_ext_addr | output | 32 | Extended address |
| tx_addr | output | 32 | Remote address |
| tx_local_addr | output | 32 | Local address |
| tx_length | output | LEN_W | Transfer length |
| tx_port | output | PORT_W | Output port number |
| tx_ptype | output | 8 | Packed packet-type byte |
| tx_hop | output | 8 | Hop count |
| tx_dbell | output | 16 | Doorbell information |
| tx_done | input | 1 | Completion strobe from the engine |
| tx_code | input | 3 | Result code accompanying tx_done |

## Verification
The bench builds the bank with LEN_W set to 12 and PORT_W set to 3. It keeps the default format mask, which supports formats 2, 5, 6, 8, 10 and 11. The narrow length makes readback truncation visible with an all-ones write. The 3-bit port shows that the port field is not fixed at two bits. The default mask leaves formats 0 and 3 unsupported, so the self-completing path can be reached with and without the interrupt hold. It also leaves formats 2, 5 and 8 next to 10, so the transaction-nibble masking can be compared between them.

// File: rtl/xdb_pkg.sv
package xdb_pkg;

    localparam int unsigned XDB_DW = 32;

    localparam logic [2:0] A_EXT   = 3'd0;
    localparam logic [2:0] A_RADDR = 3'd1;
    localparam logic [2:0] A_LADDR = 3'd2;
    localparam logic [2:0] A_LEN   = 3'd3;
    localparam logic [2:0] A_CTRL  = 3'd4;
    localparam logic [2:0] A_CMD   = 3'd5;
    localparam logic [2:0] A_STAT  = 3'd6;
    localparam logic [2:0] A_ACK   = 3'd7;

    localparam logic [2:0] RC_OK    = 3'b000;
    localparam logic [2:0] RC_UNSUP = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FAULT = 2'd2,
        ST_ACK   = 2'd3
    } xdb_state_e;

    function automatic logic fmt_supported(input logic [15:0] mask, input logic [3:0] fmt);
        return mask[fmt];
    endfunction

endpackage

// File: rtl/xdb_regfile.sv
module xdb_regfile #(
    parameter int unsigned LEN_W  = 20,
    parameter int unsigned PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       ext_addr,
    output logic [31:0]       rem_addr,
    output logic [31:0]       loc_addr,
    output logic [LEN_W-1:0]  length,
    output logic [PORT_W-1:0] port,
    output logic              irq_en,
    output logic [7:0]        hop,
    output logic [3:0]        ftype,
    output logic [3:0]        ttype,
    output logic [15:0]       dbell
);
    import xdb_pkg::*;

    typedef struct packed {
        logic [31:0]       ext_addr;
        logic [31:0]       rem_addr;
        logic [31:0]       loc_addr;
        logic [LEN_W-1:0]  length;
        logic [PORT_W-1:0] port;
        logic              irq_en;
        logic [7:0]        hop;
        logic [3:0]        ftype;
        logic [3:0]        ttype;
        logic [15:0]       dbell;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_EXT:   regs_d.ext_addr = wdata;
                A_RADDR: regs_d.rem_addr = wdata;
                A_LADDR: regs_d.loc_addr = wdata;
                A_LEN:   regs_d.length   = wdata[LEN_W-1:0];
                A_CTRL: begin
                    regs_d.port   = wdata[PORT_W-1:0];
                    regs_d.irq_en = wdata[8];
                end
                A_CMD: begin
                    regs_d.hop   = wdata[7:0];
                    regs_d.ttype = wdata[11:8];
                    regs_d.ftype = wdata[15:12];
                    regs_d.dbell = wdata[31:16];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ext_addr = regs_q.ext_addr;
    assign rem_addr = regs_q.rem_addr;
    assign loc_addr = regs_q.loc_addr;
    assign length   = regs_q.length;
    assign port     = regs_q.port;
    assign irq_en   = regs_q.irq_en;
    assign hop      = regs_q.hop;
    assign ftype    = regs_q.ftype;
    assign ttype    = regs_q.ttype;
    assign dbell    = regs_q.dbell;

endmodule

// File: rtl/xdb_hdr_pack.sv
module xdb_hdr_pack (
    input  logic [3:0] ftype,
    input  logic [3:0] ttype,
    output logic [7:0] ptype
);
    logic keeps_trans;

    always_comb begin
        unique case (ftype)
            4'd2, 4'd5, 4'd8: keeps_trans = 1'b1;
            default:          keeps_trans = 1'b0;
        endcase
        ptype = {ftype, keeps_trans ? ttype : 4'h0};
    end

endmodule

// File: rtl/xdb_ctrl.sv
module xdb_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic       fmt_ok,
    input  logic       irq_en,
    input  logic       done,
    input  logic [2:0] done_code,
    input  logic       ack,
    input  logic       viol_set,
    input  logic       viol_clr,
    output logic       busy,
    output logic       launch,
    output logic       irq,
    output logic [2:0] result,
    output logic       viol
);
    import xdb_pkg::*;

    typedef struct packed {
        xdb_state_e st;
        logic       launch;
        logic [2:0] code;
        logic       viol;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.launch = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_go) begin
                    if (fmt_ok) begin
                        ctl_d.st     = ST_WAIT;
                        ctl_d.launch = 1'b1;
                    end else begin
                        ctl_d.st = ST_FAULT;
                    end
                end
            end
            ST_WAIT: begin
                if (done) begin
                    ctl_d.code = done_code;
                    ctl_d.st   = irq_en ? ST_ACK : ST_IDLE;
                end
            end
            ST_FAULT: begin
                ctl_d.code = RC_UNSUP;
                ctl_d.st   = irq_en ? ST_ACK : ST_IDLE;
            end
            ST_ACK: begin
                if (ack) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (viol_clr) ctl_d.viol = 1'b0;
        if (viol_set) ctl_d.viol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.launch <= 1'b0;
            ctl_q.code   <= RC_OK;
            ctl_q.viol   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.st != ST_IDLE);
    assign launch = ctl_q.launch;
    assign irq    = (ctl_q.st == ST_ACK);
    assign result = ctl_q.code;
    assign viol   = ctl_q.viol;

endmodule

// File: rtl/xdb_bank.sv
module xdb_bank #(
    parameter int unsigned LEN_W       = 20,
    parameter int unsigned PORT_W      = 2,
    parameter logic [15:0] FMT_SUPPORT = 16'h0D64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              busy,
    output logic              irq,
    output logic              tx_launch,
    output logic [31:0]       tx_ext_addr,
    output logic [31:0]       tx_addr,
    output logic [31:0]       tx_local_addr,
    output logic [LEN_W-1:0]  tx_length,
    output logic [PORT_W-1:0] tx_port,
    output logic [7:0]        tx_ptype,
    output logic [7:0]        tx_hop,
    output logic [15:0]       tx_dbell,
    input  logic              tx_done,
    input  logic [2:0]        tx_code
);
    import xdb_pkg::*;

    localparam logic [2:0] LAST_DESC = A_CMD;

    logic        desc_hit, desc_wr, cmd_go, new_fmt_ok, ack, viol_clr, viol_set;
    logic        irq_en, viol;
    logic [3:0]  ftype, ttype;
    logic [2:0]  result;
    logic [31:0] len_rd;

    assign desc_hit   = (cfg_addr <= LAST_DESC);
    assign desc_wr    = cfg_wr && desc_hit && !busy;
    assign viol_set   = cfg_wr && desc_hit && busy;
    assign cmd_go     = desc_wr && (cfg_addr == A_CMD);
    assign new_fmt_ok = fmt_supported(FMT_SUPPORT, cfg_wdata[15:12]);
    assign ack        = cfg_wr && (cfg_addr == A_ACK) && cfg_wdata[0];
    assign viol_clr   = cfg_wr && (cfg_addr == A_ACK) && cfg_wdata[1];

    xdb_regfile #(.LEN_W(LEN_W), .PORT_W(PORT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (desc_wr),
        .wr_addr  (cfg_addr),
        .wdata    (cfg_wdata),
        .ext_addr (tx_ext_addr),
        .rem_addr (tx_addr),
        .loc_addr (tx_local_addr),
        .length   (tx_length),
        .port     (tx_port),
        .irq_en   (irq_en),
        .hop      (tx_hop),
        .ftype    (ftype),
        .ttype    (ttype),
        .dbell    (tx_dbell)
    );

    xdb_hdr_pack u_pack (
        .ftype (ftype),
        .ttype (ttype),
        .ptype (tx_ptype)
    );

    xdb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .fmt_ok    (new_fmt_ok),
        .irq_en    (irq_en),
        .done      (tx_done),
        .done_code (tx_code),
        .ack       (ack),
        .viol_set  (viol_set),
        .viol_clr  (viol_clr),
        .busy      (busy),
        .launch    (tx_launch),
        .irq       (irq),
        .result    (result),
        .viol      (viol)
    );

    generate
        if (LEN_W < XDB_DW) begin : g_len_pad
            assign len_rd = {{(XDB_DW - LEN_W){1'b0}}, tx_length};
        end else begin : g_len_cut
            assign len_rd = tx_length[XDB_DW-1:0];
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd) begin
            unique case (cfg_addr)
                A_EXT:   if (!busy) cfg_rdata = tx_ext_addr;
                A_RADDR: if (!busy) cfg_rdata = tx_addr;
                A_LADDR: if (!busy) cfg_rdata = tx_local_addr;
                A_LEN:   if (!busy) cfg_rdata = len_rd;
                A_CTRL: if (!busy) begin
                    cfg_rdata[PORT_W-1:0] = tx_port;
                    cfg_rdata[8]          = irq_en;
                end
                A_CMD:   if (!busy) cfg_rdata = {tx_dbell, ftype, ttype, tx_hop};
                A_STAT:  cfg_rdata[5:0] = {irq, viol, (busy ? RC_OK : result), busy};
                default: cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/xdb_checker.sv
module xdb_checker #(
    parameter logic [15:0] FMT_SUPPORT = 16'h0D64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic        cfg_rd,
    input logic [2:0]  cfg_addr,
    input logic        ack_bit,
    input logic [3:0]  new_fmt,
    input logic [2:0]  rd_result,
    input logic        busy,
    input logic        irq,
    input logic        tx_launch,
    input logic [3:0]  cur_fmt,
    input logic [31:0] tx_addr
);
    import xdb_pkg::*;

    a_r3_launch_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_launch |-> busy);

    a_r3_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_launch |=> !tx_launch);

    a_r3_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_wr && cfg_addr == A_CMD && fmt_supported(FMT_SUPPORT, new_fmt))
        |=> (tx_launch && busy));

    a_r10_launch_fmt_ok: assert property (@(posedge clk) disable iff (!rst_n)
        tx_launch |-> fmt_supported(FMT_SUPPORT, cur_fmt));

    a_r6_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr && cfg_addr == A_RADDR) |=> $stable(tx_addr));

    a_r7_result_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_rd && cfg_addr == A_STAT) |-> (rd_result == RC_OK));

    a_r9_irq_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);

    a_r9_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg_wr && cfg_addr == A_ACK && ack_bit) |=> (!busy && !irq));

endmodule

bind xdb_bank xdb_checker #(.FMT_SUPPORT(FMT_SUPPORT)) u_xdb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .ack_bit   (cfg_wdata[0]),
    .new_fmt   (cfg_wdata[15:12]),
    .rd_result (cfg_rdata[3:1]),
    .busy      (busy),
    .irq       (irq),
    .tx_launch (tx_launch),
    .cur_fmt   (tx_ptype[7:4]),
    .tx_addr   (tx_addr)
);

// File: tb/xdb_bank_bench.sv
module xdb_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;
    localparam int PORT_W     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0, cfg_rdata;
    logic              busy, irq, tx_launch, tx_done = 1'b0;
    logic [2:0]        tx_code = '0;
    logic [31:0]       tx_ext_addr, tx_addr, tx_local_addr;
    logic [LEN_W-1:0]  tx_length;
    logic [PORT_W-1:0] tx_port;
    logic [7:0]        tx_ptype, tx_hop;
    logic [15:0]       tx_dbell;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xdb_bank #(.LEN_W(LEN_W), .PORT_W(PORT_W)) u_xdb_bank (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .irq(irq), .tx_launch(tx_launch),
        .tx_ext_addr(tx_ext_addr), .tx_addr(tx_addr), .tx_local_addr(tx_local_addr),
        .tx_length(tx_length), .tx_port(tx_port), .tx_ptype(tx_ptype),
        .tx_hop(tx_hop), .tx_dbell(tx_dbell), .tx_done(tx_done), .tx_code(tx_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input logic b, input logic [2:0] c,
                                         input logic v, input logic i);
        return {26'b0, i, v, c, b};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_rd = 1'b1; cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse_done(input logic [2:0] c);
        @(negedge clk);
        tx_done = 1'b1; tx_code = c;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    function automatic logic [31:0] cmd(input logic [3:0] f, input logic [3:0] t,
                                        input logic [7:0] h, input logic [15:0] db);
        return {db, f, t, h};
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 launch", {31'b0, tx_launch}, 0);
        rd(3'd6, v); chk("R1 status", v, 0);
    endtask

    task automatic t_desc_rw;
        logic [31:0] v;
        wr(3'd0, 32'h1234_5678); wr(3'd1, 32'hA5A5_0001);
        wr(3'd2, 32'h0BAD_F00D); wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0000_0005);
        rd(3'd0, v); chk("R2 ext readback", v, 32'h1234_5678);
        rd(3'd1, v); chk("R2 raddr readback", v, 32'hA5A5_0001);
        rd(3'd2, v); chk("R2 laddr readback", v, 32'h0BAD_F00D);
        rd(3'd3, v); chk("R2 len truncated", v, 32'h0000_0FFF);
        rd(3'd4, v); chk("R2 ctrl readback", v, 32'h0000_0005);
        chk("R2 tx_ext_addr", tx_ext_addr, 32'h1234_5678);
        chk("R2 tx_addr", tx_addr, 32'hA5A5_0001);
        chk("R2 tx_local_addr", tx_local_addr, 32'h0BAD_F00D);
        chk("R2 tx_length", {20'b0, tx_length}, 32'hFFF);
    endtask

    task automatic t_launch_fmt5;
        logic [31:0] v;
        wr(3'd5, cmd(4'd5, 4'd4, 8'h3C, 16'hBEEF));
        chk("R3 busy after cmd", {31'b0, busy}, 1);
        chk("R3 launch after cmd", {31'b0, tx_launch}, 1);
        chk("R4 ptype fmt5", {24'b0, tx_ptype}, 32'h54);
        chk("R5 hop", {24'b0, tx_hop}, 32'h3C);
        chk("R5 dbell", {16'b0, tx_dbell}, 32'hBEEF);
        chk("R5 port", {29'b0, tx_port}, 32'h5);
        @(negedge clk);
        chk("R3 launch single", {31'b0, tx_launch}, 0);
        rd(3'd6, v); chk("R7 hidden while busy", v, stat(1, 0, 0, 0));
        pulse_done(3'b010);
        chk("R8 busy drops", {31'b0, busy}, 0);
        chk("R8 no irq", {31'b0, irq}, 0);
        rd(3'd6, v); chk("R7 code captured", v, stat(0, 3'b010, 0, 0));
    endtask

    task automatic t_ptype_variants;
        wr(3'd5, cmd(4'd10, 4'd7, 8'h00, 16'h0001));
        chk("R4 fmt10 trans masked", {24'b0, tx_ptype}, 32'hA0);
        pulse_done(3'b000);
        wr(3'd5, cmd(4'd8, 4'd1, 8'hFF, 16'h0000));
        chk("R4 fmt8 trans kept", {24'b0, tx_ptype}, 32'h81);
        chk("R5 hop fmt8", {24'b0, tx_hop}, 32'hFF);
        pulse_done(3'b000);
        wr(3'd5, cmd(4'd2, 4'd9, 8'h00, 16'h0000));
        chk("R4 fmt2 trans kept", {24'b0, tx_ptype}, 32'h29);
        pulse_done(3'b000);
        wr(3'd5, cmd(4'd6, 4'd3, 8'h00, 16'h0000));
        chk("R4 fmt6 trans masked", {24'b0, tx_ptype}, 32'h60);
        pulse_done(3'b000);
    endtask

    task automatic t_busy_block;
        logic [31:0] v;
        wr(3'd1, 32'h1111_1111);
        wr(3'd5, cmd(4'd5, 4'd0, 8'h00, 16'h0000));
        wr(3'd1, 32'h2222_2222);
        rd(3'd1, v); chk("R6 read blocked", v, 0);
        rd(3'd6, v); chk("R6 viol set", v, stat(1, 0, 1, 0));
        chk("R6 tx_addr unchanged", tx_addr, 32'h1111_1111);
        pulse_done(3'b001);
        rd(3'd1, v); chk("R6 write dropped", v, 32'h1111_1111);
        rd(3'd6, v); chk("R6 viol sticky", v, stat(0, 3'b001, 1, 0));
        wr(3'd7, 32'h2);
        rd(3'd6, v); chk("R6 viol cleared", v, stat(0, 3'b001, 0, 0));
    endtask

    task automatic t_irq_hold;
        logic [31:0] v;
        wr(3'd4, 32'h0000_0103);
        wr(3'd5, cmd(4'd11, 4'd0, 8'h00, 16'h0000));
        pulse_done(3'b110);
        chk("R9 irq up", {31'b0, irq}, 1);
        chk("R9 busy held", {31'b0, busy}, 1);
        rd(3'd6, v); chk("R7 hidden while irq", v, stat(1, 0, 0, 1));
        repeat (3) @(negedge clk);
        chk("R9 still busy", {31'b0, busy}, 1);
        wr(3'd7, 32'h1);
        chk("R9 busy released", {31'b0, busy}, 0);
        chk("R9 irq cleared", {31'b0, irq}, 0);
        rd(3'd6, v); chk("R9 code after ack", v, stat(0, 3'b110, 0, 0));
    endtask

    task automatic t_unsupported;
        logic [31:0] v;
        wr(3'd4, 32'h0000_0000);
        wr(3'd5, cmd(4'd3, 4'd0, 8'h00, 16'h0000));
        chk("R10 no launch", {31'b0, tx_launch}, 0);
        chk("R10 busy one cycle", {31'b0, busy}, 1);
        @(negedge clk);
        chk("R10 idle again", {31'b0, busy}, 0);
        chk("R10 still no launch", {31'b0, tx_launch}, 0);
        rd(3'd6, v); chk("R10 code 100", v, stat(0, 3'b100, 0, 0));
        wr(3'd4, 32'h0000_0100);
        wr(3'd5, cmd(4'd0, 4'd0, 8'h00, 16'h0000));
        @(negedge clk);
        chk("R10 irq on unsupported", {31'b0, irq}, 1);
        chk("R10 busy held for ack", {31'b0, busy}, 1);
        wr(3'd7, 32'h1);
        rd(3'd6, v); chk("R10 after ack", v, stat(0, 3'b100, 0, 0));
    endtask

    task automatic t_idle_done;
        logic [31:0] v;
        pulse_done(3'b111);
        rd(3'd6, v); chk("R11 idle done ignored", v, stat(0, 3'b100, 0, 0));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_desc_rw();
        t_launch_fmt5();
        t_ptype_variants();
        t_busy_block();
        t_irq_hold();
        t_unsupported();
        t_idle_done();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule